// File: doc/BRIEF.md
# Burst Length Histogram Monitor

A passive observer for a parallel bus with a frame strobe, two ready strobes and a four-bit command/byte-enable bus, all active low. It never drives the bus. A transaction begins in the clock where the frame strobe is first seen low. The command on the command lines in that clock increments one of sixteen per-command counters. During a memory-type transaction, each unbroken run of clocks in which the initiator-ready and target-ready strobes are both low is timed. The run's length is then sorted into one of sixteen histogram bins.

An optional qualifier restricts the statistics to the traffic of one master. When qualification is on, address phases and data clocks count only while that master's grant line is low. A combinational read port returns any of the thirty-two counters. A synchronous clear input zeroes them all in a single clock.

Top module: `burst_histo_mon`

## Requirements
- R1: After reset, and in the clock after `clr` is sampled high, every one of the 32 read addresses returns 0.
- R2: A clock with `frame_n` low, where `frame_n` was high in the previous clock, is an address phase. It increments the counter at read address 16+`cbe_n` (the raw four-bit command value). Clocks in which `frame_n` stays low do not count again.
- R3: A run is a maximal series of clocks with `irdy_n` and `trdy_n` both low. A run of L clocks increments bin L/2 (integer division) for L below 30, and bin 15 for L of 30 or more. Bin k is read at address k.
- R4: Only runs inside transactions whose command is 0110, 0111, 1100, 1110 or 1111 update the bins. Runs under any other command leave every bin unchanged. Such transactions still count in their command counter.
- R5: With `qual_en` high, an address phase or a data clock counts only while `gnt_n` is low. A run also ends in a clock where `gnt_n` is high. With `qual_en` low, `gnt_n` has no effect.
- R6: Every counter saturates at 2^CW-1 and never wraps to zero.
- R7: The bin for a run changes on `rd_data` in the clock right after the first clock in which either ready strobe is high. It does not change earlier.
- R8: `clr` also discards the part of a run seen up to and including the clear clock. Clocks after it start a new length count. `clr` does not forget whether the current transaction is a memory transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all counters and the run length |
| frame_n | input | 1 | Frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| cbe_n | input | 4 | Command / byte-enable lines |
| gnt_n | input | 1 | Grant of the master to qualify on, active low |
| qual_en | input | 1 | Enable grant qualification |
| rd_addr | input | 5 | Counter select: 0-15 bins, 16-31 command counters |
| rd_data | output | CW | Selected counter value |

## Verification
A command count appears on `rd_data` in the clock after its address-phase edge. A bin count appears in the clock after the first edge that sees a ready strobe high. A clear shows in the clock after it is sampled. The bench drives every input on the falling edge and reads each result half a clock after the rising edge that should produce it. For every memory burst, it reads the target bin both before and after the ending edge, so that a result arriving one cycle early or late is caught. The bench sweeps all run lengths from 1 to 33, all sixteen command codes, both qualifier settings, saturation and a clear inside a run, against a counter model kept in the bench.

// File: rtl/burst_histo_mon.sv
module burst_histo_mon #(
  parameter int CW = 16,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          trdy_n,
  input  logic [3:0]    cbe_n,
  input  logic          gnt_n,
  input  logic          qual_en,
  input  logic [4:0]    rd_addr,
  output logic [CW-1:0] rd_data
);
  localparam int NB = 16;
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};
  localparam logic [LW-1:0] LTOP = LW'(30);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          frame_q, mem_txn;
  logic [LW-1:0] run_len;
  logic [CW-1:0] bin_cnt [NB];
  logic [CW-1:0] cmd_cnt [NB];

  wire qual_ok    = !qual_en || !gnt_n;
  wire frame_rise = !frame_n && frame_q;
  wire addr_ph    = frame_rise && qual_ok;
  wire cmd_is_mem = (cbe_n == 4'h6) || (cbe_n == 4'h7) || (cbe_n == 4'hC) ||
                    (cbe_n == 4'hE) || (cbe_n == 4'hF);
  wire act        = !irdy_n && !trdy_n && qual_ok && mem_txn;
  wire burst_end  = !act && (run_len != '0);
  wire [3:0] bin_idx = (run_len >= LTOP) ? 4'd15 : 4'(run_len >> 1);

  assign rd_data = rd_addr[4] ? cmd_cnt[rd_addr[3:0]] : bin_cnt[rd_addr[3:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      mem_txn <= 1'b0;
    end else begin
      frame_q <= frame_n;
      if (frame_rise) mem_txn <= cmd_is_mem && qual_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_len <= '0;
    else if (clr || !act)      run_len <= '0;
    else if (run_len != LMAX)  run_len <= run_len + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        bin_cnt[i] <= '0;
        cmd_cnt[i] <= '0;
      end
    end else if (clr) begin
      for (int i = 0; i < NB; i++) begin
        bin_cnt[i] <= '0;
        cmd_cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (burst_end && bin_idx == 4'(i) && bin_cnt[i] != CMAX)
          bin_cnt[i] <= bin_cnt[i] + 1'b1;
        if (addr_ph && cbe_n == 4'(i) && cmd_cnt[i] != CMAX)
          cmd_cnt[i] <= cmd_cnt[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_histo_chk.sv
module burst_histo_chk #(
  parameter int CW = 16,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          act,
  input logic [LW-1:0] run_len,
  input logic [4:0]    rd_addr,
  input logic [CW-1:0] rd_data
);
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_data == '0));

  a_r8_clear_len: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (run_len == '0));

  a_r3_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !clr && run_len != LMAX) |=> (run_len == $past(run_len) + 1'b1));

  a_r3_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (run_len == '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && $stable(rd_addr)) |-> (rd_data >= $past(rd_data)));
endmodule

bind burst_histo_mon burst_histo_chk #(.CW(CW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .act(act), .run_len(run_len),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/burst_histo_mon_tb.sv
module burst_histo_mon_tb_top;
  localparam int CLK_P = 10;
  localparam int CW = 4;
  localparam int MAXV = 15;

  logic clk = 0, rst_n = 0, clr = 0, frame_n = 1, irdy_n = 1, trdy_n = 1;
  logic gnt_n = 1, qual_en = 0;
  logic [3:0] cbe_n = 4'hF;
  logic [4:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int exp_bin [16];
  int exp_cmd [16];

  always #(CLK_P/2) clk = ~clk;

  burst_histo_mon #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .cbe_n(cbe_n), .gnt_n(gnt_n), .qual_en(qual_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int sat(int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  function automatic bit is_mem(logic [3:0] c);
    return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic zero_model();
    for (int i = 0; i < 16; i++) begin exp_bin[i] = 0; exp_cmd[i] = 0; end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      rd_addr = 5'(a);
      #1;
      chk(tag, int'(rd_data), a < 16 ? exp_bin[a] : exp_cmd[a-16]);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    zero_model();
  endtask

  task automatic txn(logic [3:0] cmd, int len, logic g);
    bit q, cnt;
    int b;
    q = !qual_en || !g;
    cnt = q && is_mem(cmd) && len > 0;
    b = (len >= 30) ? 15 : len / 2;
    @(negedge clk);
    frame_n = 0; cbe_n = cmd; gnt_n = g;
    if (q) exp_cmd[cmd] = sat(exp_cmd[cmd]);
    @(negedge clk);
    frame_n = 1; cbe_n = 4'hF;
    if (len > 0) begin
      irdy_n = 0; trdy_n = 0;
      repeat (len) @(negedge clk);
    end
    irdy_n = 1; trdy_n = 1;
    rd_addr = 5'(b);
    #1;
    if (cnt) chk("R7 before end", int'(rd_data), exp_bin[b]);
    if (cnt) exp_bin[b] = sat(exp_bin[b]);
    @(negedge clk);
    #1;
    if (cnt) chk("R7 after end", int'(rd_data), exp_bin[b]);
    gnt_n = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    zero_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");

    for (int l = 1; l <= 33; l++) txn(4'h6, l, 1'b1);
    check_all("R3 length sweep");

    do_clear();
    check_all("R1 clear");

    for (int c = 0; c < 16; c++) txn(4'(c), 4, 1'b1);
    check_all("R2 R4 command sweep");

    do_clear();
    qual_en = 1;
    txn(4'h7, 4, 1'b1);
    txn(4'h6, 8, 1'b0);
    txn(4'h2, 3, 1'b1);
    qual_en = 0;
    txn(4'hC, 11, 1'b1);
    check_all("R5 qualify");

    do_clear();
    for (int k = 0; k < 20; k++) txn(4'h7, 1, 1'b0);
    check_all("R6 saturate");

    do_clear();
    @(negedge clk); frame_n = 0; cbe_n = 4'h7;
    @(negedge clk); frame_n = 1; cbe_n = 4'hF; irdy_n = 0; trdy_n = 0; clr = 1;
    @(negedge clk);
    @(negedge clk); clr = 0;
    repeat (4) @(negedge clk);
    irdy_n = 1; trdy_n = 1;
    @(negedge clk);
    zero_model();
    exp_bin[2] = 1;
    check_all("R8 clear in run");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule